// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped general purpose I/O port of up to sixteen pins. A host reaches it through a simple synchronous 32-bit register interface: byte address, write enable, write data and a registered read data word. For every pin there is an output data bit, a direction bit that becomes the pad output-enable, a synchronised input sample, and an interrupt detector with its own trigger mode, enable, mask and sticky status bit.

Input pins pass through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. Level modes keep raising their status bit for as long as the level lasts. All unmasked, enabled, pending status bits are ORed into one registered interrupt line. A write-only soft-reset word holds every port register at its default for as long as its bit 0 is 1.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every readable register reads 0, pins_out and pins_oe are 0 and irq is 0.
- R2: Word offsets (byte address): 0x00 interrupt enable, 0x18 output data, 0x20 direction read back what was written. pins_out follows output data and pins_oe follows direction (1 = output). Bits at or above NUM_PINS read 0.
- R3: Trigger mode is 3 bits per pin in a 4-bit slot: pins 0..7 in the mode word at 0x24 at bit pin*4, pins 8..15 in the mode word at 0x28 at bit (pin-8)*4. Bit 3 of each slot and slots of absent pins read 0.
- R4: The input word at 0x1C returns the synchronised pins_in levels; bits at or above NUM_PINS read 0.
- R5: Edge modes: code 0 falling, 1 rising, 4 both edges. A status bit (read at 0x04) is set only when the pin's enable bit is 1 when the edge is seen. Codes 5, 6, 7 never set status.
- R6: Level modes: code 2 low, 3 high. While enabled and the level persists, status is set again after every clear.
- R7: Writing 1 to a bit of the clear word at 0x0C clears that status bit; 0 bits have no effect. When a clear and a trigger happen in the same cycle the status bit stays 1.
- R8: Writing 1 to a bit at 0x10 masks that pin; writing 1 at 0x14 unmasks it; 0 bits leave the mask unchanged. Reading 0x10 returns the mask; 0x14 and 0x0C read 0.
- R9: irq is 1 exactly one cycle after some pin has status, enable and not mask all 1; the word at 0x08 reads status AND enable AND NOT mask.
- R10: Bit 0 of the write-only word at 0x3C is the soft reset. While it is 1 all other registers and status read 0 and writes to them are ignored; writing 0 releases it. It reads 0.
- R11: A status bit is sticky: it stays 1 after the trigger is gone and after the enable bit is cleared, until cleared through the clear word or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register word |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the address of the previous cycle |
| pins_in | input | NUM_PINS | Asynchronous pin levels |
| pins_out | output | NUM_PINS | Output data to the pads |
| pins_oe | output | NUM_PINS | Output enable to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with NUM_PINS of 12, so pins 8 to 11 live in the second mode word while its upper slots and bits 12 to 31 of every per-pin word stay unused and must read zero. This also leaves some data bits written as 1 that have no pin behind them, which exposes decode that does not trim to the pin count. Random register writes, including the unused mode codes 5 to 7, are interleaved with random pin changes, and a bench model of status, mask and irq is compared after each step; directed cases cover the clear that meets a trigger in the same cycle, level retriggering after clear and writes ignored under soft reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam int OFS_EN    = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_VIEW  = 2;
  localparam int OFS_CLR   = 3;
  localparam int OFS_MSET  = 4;
  localparam int OFS_MCLR  = 5;
  localparam int OFS_OUT   = 6;
  localparam int OFS_IN    = 7;
  localparam int OFS_DIR   = 8;
  localparam int OFS_MODE0 = 9;
  localparam int OFS_MODE1 = 10;
  localparam int OFS_SRST  = 15;

  localparam int SLOT_W    = 4;
  localparam int MODE_W    = 3;
  localparam int SLOTS_PER = 8;

  function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                    input logic cur, input logic prev);
    logic hit;
    case (mode)
      TRIG_FALL: hit = prev & ~cur;
      TRIG_RISE: hit = ~prev & cur;
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cur,
  input  logic              prev,
  input  logic [MODE_W-1:0] mode,
  input  logic              enable,
  input  logic              clear,
  output logic              status
);
  logic status_q;
  logic fire;

  assign fire = enable & trig_hit(mode, cur, prev);

  always_ff @(posedge clk) begin
    if (rst || flush)   status_q <= 1'b0;
    else if (fire)      status_q <= 1'b1;
    else if (clear)     status_q <= 1'b0;
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic [NUM_PINS-1:0] pins_out,
  output logic [NUM_PINS-1:0] pins_oe,
  output logic                irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic [NUM_PINS-1:0] wd;
  logic                wr_ok;
  logic                we_en, we_clr, we_mset, we_mclr;
  logic                we_out, we_dir, we_mode0, we_mode1, we_srst;

  logic                srst_q;
  logic [NUM_PINS-1:0] irq_en_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [MODE_W-1:0]   mode_q [NUM_PINS];
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] sync_cur;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] pending;
  logic                irq_q;
  logic [DATA_W-1:0]   rd_next;
  logic [DATA_W-1:0]   rd_q;
  logic [DATA_W-1:0]   mode0_word, mode1_word;

  assign word  = addr[ADDR_W-1:2];
  assign wd    = wdata[NUM_PINS-1:0];
  assign wr_ok = wr_en & ~srst_q;

  assign we_en    = wr_ok && (word == WORD_W'(OFS_EN));
  assign we_clr   = wr_ok && (word == WORD_W'(OFS_CLR));
  assign we_mset  = wr_ok && (word == WORD_W'(OFS_MSET));
  assign we_mclr  = wr_ok && (word == WORD_W'(OFS_MCLR));
  assign we_out   = wr_ok && (word == WORD_W'(OFS_OUT));
  assign we_dir   = wr_ok && (word == WORD_W'(OFS_DIR));
  assign we_mode0 = wr_ok && (word == WORD_W'(OFS_MODE0));
  assign we_mode1 = wr_ok && (word == WORD_W'(OFS_MODE1));
  assign we_srst  = wr_en && (word == WORD_W'(OFS_SRST));

  always_ff @(posedge clk) begin
    if (rst)          srst_q <= 1'b0;
    else if (we_srst) srst_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      irq_en_q <= '0;
      mask_q   <= '0;
      out_q    <= '0;
      dir_q    <= '0;
    end else begin
      if (we_en)   irq_en_q <= wd;
      if (we_out)  out_q    <= wd;
      if (we_dir)  dir_q    <= wd;
      if (we_mset) mask_q   <= mask_q | wd;
      if (we_mclr) mask_q   <= mask_q & ~wd;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rst || srst_q) begin
        mode_q[p] <= MODE_W'(TRIG_FALL);
      end else if (p < SLOTS_PER) begin
        if (we_mode0) mode_q[p] <= wdata[(p % SLOTS_PER)*SLOT_W +: MODE_W];
      end else begin
        if (we_mode1) mode_q[p] <= wdata[(p % SLOTS_PER)*SLOT_W +: MODE_W];
      end
    end
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pins_in),
    .sync_out (sync_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_cur;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_trig_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .flush  (srst_q),
      .cur    (sync_cur[g]),
      .prev   (prev_q[g]),
      .mode   (mode_q[g]),
      .enable (irq_en_q[g]),
      .clear  (we_clr & wd[g]),
      .status (status[g])
    );
  end

  assign pending = status & irq_en_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending;
  end

  always_comb begin
    mode0_word = '0;
    mode1_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (p < SLOTS_PER) mode0_word[(p % SLOTS_PER)*SLOT_W +: MODE_W] = mode_q[p];
      else               mode1_word[(p % SLOTS_PER)*SLOT_W +: MODE_W] = mode_q[p];
    end
  end

  always_comb begin
    rd_next = '0;
    case (word)
      WORD_W'(OFS_EN):    rd_next = DATA_W'(irq_en_q);
      WORD_W'(OFS_STAT):  rd_next = DATA_W'(status);
      WORD_W'(OFS_VIEW):  rd_next = DATA_W'(pending);
      WORD_W'(OFS_MSET):  rd_next = DATA_W'(mask_q);
      WORD_W'(OFS_OUT):   rd_next = DATA_W'(out_q);
      WORD_W'(OFS_IN):    rd_next = DATA_W'(sync_cur);
      WORD_W'(OFS_DIR):   rd_next = DATA_W'(dir_q);
      WORD_W'(OFS_MODE0): rd_next = mode0_word;
      WORD_W'(OFS_MODE1): rd_next = mode1_word;
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data  = rd_q;
  assign pins_out = out_q;
  assign pins_oe  = dir_q;
  assign irq      = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wdata,
  input logic                srst_q,
  input logic [NUM_PINS-1:0] irq_en_q,
  input logic [NUM_PINS-1:0] mask_q,
  input logic [NUM_PINS-1:0] status,
  input logic                irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic                wr_live;
  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] live;

  assign word    = addr[ADDR_W-1:2];
  assign wr_live = wr_en & ~srst_q;
  assign clr_w   = (wr_live && word == WORD_W'(OFS_CLR)) ? wdata[NUM_PINS-1:0] : '0;
  assign live    = status & irq_en_q & ~mask_q;

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_live && word == WORD_W'(OFS_MSET)) |=>
      ((mask_q & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0])));

  // R8
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_live && word == WORD_W'(OFS_MCLR)) |=>
      ((mask_q & $past(wdata[NUM_PINS-1:0])) == '0));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(live) != '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |=> !irq);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(srst_q) |-> (irq_en_q == '0 && mask_q == '0 && status == '0));

  // R11
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(srst_q) |-> (($past(status) & ~status & ~$past(clr_w)) == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .srst_q   (srst_q),
  .irq_en_q (irq_en_q),
  .mask_q   (mask_q),
  .status   (status),
  .irq      (irq)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int NP = 12;
  localparam logic [31:0] PM = (32'd1 << NP) - 1;
  localparam logic [5:0] A_EN = 6'h00, A_STAT = 6'h04, A_VIEW = 6'h08, A_CLR = 6'h0C,
                         A_MSET = 6'h10, A_MCLR = 6'h14, A_OUT = 6'h18, A_IN = 6'h1C,
                         A_DIR = 6'h20, A_M0 = 6'h24, A_M1 = 6'h28, A_SRST = 6'h3C;

  logic clk = 0, rst = 1, wr_en = 0, irq;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rd_data;
  logic [NP-1:0] pins = '0, pins_out, pins_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NP-1:0] m_en, m_mask, m_out, m_dir, m_stat, m_pins;
  logic [2:0] m_mode [NP];

  always #2 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .ADDR_W(6), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .pins_in(pins), .pins_out(pins_out),
    .pins_oe(pins_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk); v = rd_data;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mode_word(input int hi);
    logic [31:0] w = '0;
    for (int p = 0; p < NP; p++)
      if ((p >= 8) == (hi != 0)) w[(p % 8)*4 +: 3] = m_mode[p];
    return w;
  endfunction

  function automatic void apply_level();
    for (int p = 0; p < NP; p++)
      if (m_en[p] && ((m_mode[p] == 3'd2 && !m_pins[p]) || (m_mode[p] == 3'd3 && m_pins[p])))
        m_stat[p] = 1'b1;
  endfunction

  function automatic void apply_edge(input logic [NP-1:0] o, input logic [NP-1:0] n);
    for (int p = 0; p < NP; p++)
      if (m_en[p] && ((m_mode[p] == 3'd0 && o[p] && !n[p]) ||
                      (m_mode[p] == 3'd1 && !o[p] && n[p]) ||
                      (m_mode[p] == 3'd4 && o[p] != n[p])))
        m_stat[p] = 1'b1;
  endfunction

  function automatic void model_reset();
    m_en = '0; m_mask = '0; m_out = '0; m_dir = '0; m_stat = '0;
    for (int p = 0; p < NP; p++) m_mode[p] = 3'd0;
  endfunction

  task automatic pin_step(input logic [NP-1:0] n);
    logic [NP-1:0] o = m_pins;
    @(negedge clk); pins = n;
    m_pins = n;
    apply_edge(o, n);
    apply_level();
    settle(5);
  endtask

  task automatic verify_all(input string tag);
    logic [31:0] v;
    rd(A_STAT, v); chk({tag, " R5 R11 status"}, v, {20'd0, m_stat});
    rd(A_VIEW, v); chk({tag, " R9 view"}, v, {20'd0, m_stat & m_en & ~m_mask});
    rd(A_MSET, v); chk({tag, " R8 mask"}, v, {20'd0, m_mask});
    rd(A_EN,   v); chk({tag, " R2 enable"}, v, {20'd0, m_en});
    rd(A_IN,   v); chk({tag, " R4 input"}, v, {20'd0, m_pins});
    rd(A_M0,   v); chk({tag, " R3 mode0"}, v, mode_word(0));
    rd(A_M1,   v); chk({tag, " R3 mode1"}, v, mode_word(1));
    chk({tag, " R9 irq"}, {31'd0, irq}, {31'd0, |(m_stat & m_en & ~m_mask)});
    chk({tag, " R2 pins_out"}, {20'd0, pins_out}, {20'd0, m_out});
    chk({tag, " R2 pins_oe"}, {20'd0, pins_oe}, {20'd0, m_dir});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    model_reset();
    m_pins = '0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    settle(2);

    // R1 reset state
    rd(A_OUT, v);  chk("R1 out", v, 0);
    rd(A_DIR, v);  chk("R1 dir", v, 0);
    rd(A_CLR, v);  chk("R1 clr reads 0", v, 0);
    rd(A_MCLR, v); chk("R1 mclr reads 0", v, 0);
    rd(A_SRST, v); chk("R1 srst reads 0", v, 0);
    verify_all("R1");

    // R2 readback with upper bits trimmed
    wr(A_OUT, 32'hFFFF_FFFF); m_out = '1;
    wr(A_DIR, 32'hFFFF_0A5A); m_dir = 12'hA5A;
    rd(A_OUT, v); chk("R2 out trim", v, PM);
    rd(A_DIR, v); chk("R2 dir", v, 32'h0000_0A5A);

    // R3 slot packing
    wr(A_M0, 32'hFFFF_FFFF); wr(A_M1, 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) m_mode[p] = 3'd7;
    rd(A_M0, v); chk("R3 mode0 slots", v, 32'h7777_7777);
    rd(A_M1, v); chk("R3 mode1 slots", v, 32'h0000_7777);

    // R5 codes 5..7 never trigger, R4 input
    wr(A_EN, 32'hFFFF_FFFF); m_en = '1;
    pin_step(12'hFFF); pin_step(12'h000);
    verify_all("R5 unused codes");

    // R7 clear meets rising edge in the same cycle
    wr(A_M0, 32'h1); wr(A_M1, 32'h0);
    for (int p = 0; p < NP; p++) m_mode[p] = (p == 0) ? 3'd1 : 3'd0;
    wr(A_EN, 32'h1); m_en = 12'h001;
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = A_CLR; wdata = 32'h1; wr_en = 1;
    @(negedge clk); wr_en = 0;
    m_pins = pins; m_stat[0] = 1'b1;
    settle(3);
    rd(A_STAT, v); chk("R7 event wins over clear", v, 32'h1);
    // R7 zero bits no effect, one bit clears
    wr(A_CLR, 32'hFFFF_FFFE); rd(A_STAT, v); chk("R7 zero bits ignored", v, 32'h1);
    wr(A_CLR, 32'h1); m_stat[0] = 1'b0; rd(A_STAT, v); chk("R7 clear", v, 32'h0);

    // R6 level high retriggers after clear
    wr(A_M0, 32'h3); m_mode[0] = 3'd3;
    apply_level(); settle(3);
    rd(A_STAT, v); chk("R6 level set", v, 32'h1);
    wr(A_CLR, 32'h1); settle(2);
    rd(A_STAT, v); chk("R6 level re-set after clear", v, 32'h1);

    // R11 sticky after enable off and level gone
    wr(A_EN, 32'h0); m_en = '0;
    pin_step(12'h000);
    rd(A_STAT, v); chk("R11 sticky", v, 32'h1);

    // R8/R9 mask and irq
    wr(A_EN, 32'h1); m_en = 12'h001; settle(3);
    chk("R9 irq pending", {31'd0, irq}, 32'd1);
    wr(A_MSET, 32'h0000_0003); m_mask = 12'h003; settle(3);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    rd(A_MSET, v); chk("R8 mask set", v, 32'h3);
    wr(A_MCLR, 32'h0000_0002); m_mask = 12'h001;
    rd(A_MSET, v); chk("R8 mask clear one bit", v, 32'h1);
    verify_all("R8");

    // R10 soft reset holds and ignores writes
    wr(A_SRST, 32'h1);
    wr(A_EN, 32'hFFF); wr(A_OUT, 32'hFFF);
    rd(A_EN, v); chk("R10 write ignored", v, 0);
    rd(A_SRST, v); chk("R10 srst reads 0", v, 0);
    wr(A_SRST, 32'h0);
    model_reset(); settle(3);
    verify_all("R10");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] r;
      op = $urandom % 9;
      r = $urandom;
      case (op)
        0: begin wr(A_EN, r); m_en = r[NP-1:0]; apply_level(); end
        1: begin wr(A_MSET, r & $urandom); m_mask = m_mask | wdata[NP-1:0]; end
        2: begin wr(A_MCLR, r & $urandom); m_mask = m_mask & ~wdata[NP-1:0]; end
        3: begin wr(A_CLR, r); m_stat = m_stat & ~r[NP-1:0]; apply_level(); end
        4: begin wr(A_M0, r);
                 for (int p = 0; p < 8; p++) m_mode[p] = r[p*4 +: 3]; apply_level(); end
        5: begin wr(A_M1, r);
                 for (int p = 8; p < NP; p++) m_mode[p] = r[(p-8)*4 +: 3]; apply_level(); end
        6: begin wr(A_OUT, r); m_out = r[NP-1:0]; end
        7: begin wr(A_DIR, r); m_dir = r[NP-1:0]; end
        default: pin_step(r[NP-1:0]);
      endcase
      settle(4);
      if (it % 3 == 0) verify_all("random");
      else begin
        rd(A_STAT, v); chk("random R5 R6 R7 status", v, {20'd0, m_stat});
        chk("random R9 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en & ~m_mask)});
      end
    end

    finish_run();
  end
endmodule